// File: doc/BRIEF.md
# Multi-mode phase-coded sine generator

This block feeds an external DAC with a continuous stream of 8-bit sine amplitude codes. The codes are phase-shifted according to the symbols of a radar pulse compression code. A mode input selects the code family: binary, ternary, quaternary, five-phase or six-phase. Each symbol occupies a fixed window of 64 clocks. At the boundary between windows, the block samples the mode and the symbol. It converts the pair to a starting index in a one-period sine table, and from there it walks that table once per clock.

One table and one loadable phase counter serve every code family. The table holds one period in 3° steps, so it has 120 entries. Every phase that any family needs then lands on an exact index. The phase counter wraps modulo 120, independently of the 64-clock symbol window. A symbol code that a family does not define, the ternary "off" symbol and an undefined mode all silence the output for the whole window. A one-cycle request strobe tells the upstream sequence logic when the next symbol is taken.

Top module: `pcg_sine_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample` becomes 0x80 and `sample_vld` becomes 0. In the first cycle after reset is released, `sym_req` is high.
- R2: `sym_req` is high for exactly one cycle in every 64 clocks.
- R3: `mode` and `sym` are sampled only at the clock edge that closes a cycle with `sym_req` high. Values applied at any other time have no effect on the output.
- R4: Let B be the edge that samples a symbol with start index S. Sample k (k = 0..63) appears after edge B+1+k and equals T[(S+k) mod 120]. For angle a = 3i, let h = a mod 180 and p = h*(180-h). Then T[i] = 128 + (508*p)/(40500-p) when a < 180, and T[i] = 128 - (508*p)/(40500-p) otherwise, using truncating integer division.
- R5: Mode 0 is binary. `sym[0]` = 0 selects 0° and 1 selects 180°. `sym[2:1]` are ignored.
- R6: Mode 1 is ternary, decoded on `sym[1:0]`. 01 selects 0° and 11 selects 180°. 00 (off) and 10 silence the window.
- R7: Mode 2 is quaternary. `sym[1:0]` values 00, 01, 10 and 11 select 0°, 90°, 180° and 270°.
- R8: Mode 3 is five-phase. 001 selects 0°, 101 selects 72°, 011 selects 144°, 111 selects 216° and 000 selects 288°. The codes 010, 100 and 110 silence the window.
- R9: Mode 4 is six-phase. Codes 000 to 101 select 0°, 60°, 120°, 180°, 240° and 300°. Codes 110 and 111 silence the window.
- R10: Mode values 5, 6 and 7 silence the window.
- R11: A silenced window outputs `sample` = 0x80 with `sample_vld` low for all 64 samples. A started phase has start index S = degrees/3, and its 64 samples carry `sample_vld` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low clear |
| mode | input | 3 | Code family select |
| sym | input | 3 | Current code symbol |
| sym_req | output | 1 | One-cycle strobe; mode and symbol are taken at its closing edge |
| sample | output | 8 | Offset-binary sine amplitude for the DAC |
| sample_vld | output | 1 | High while a phase is being output |

## Verification
The symbol reload and the modulo-120 wrap of the phase counter can fall close together. In addition, a mode change and a symbol change always land on the same boundary edge. The bench drives symbols back to back and switches mode between consecutive windows. The last sample of the old window and the first sample of the new one are both predicted, so a reload that slips a cycle or keeps part of the old mapping is caught. Start indices of 60 and above force the wrap in the middle of a window. Right after each boundary the inputs are scrambled to show they are not sampled outside the strobe.

// File: rtl/pcg_pkg.sv
// Package: shared mode codes and degree helpers for the phase-coded sine generator.
// Assumes the mode field is 3 bits wide; values above MODE_HEXA are reserved.
package pcg_pkg;

    typedef enum logic [2:0] {
        MODE_BIN   = 3'd0,
        MODE_TER   = 3'd1,
        MODE_QUAD  = 3'd2,
        MODE_PENTA = 3'd3,
        MODE_HEXA  = 3'd4
    } pcg_mode_e;

    localparam int FULL_TURN_DEG = 360;
    localparam int HALF_TURN_DEG = 180;

endpackage

// File: rtl/pcg_symbol_timer.sv
// Module: free-running down-counter that marks each symbol window.
// Assumes SYM_LEN >= 2. The counter clears to its terminal value, so a
// boundary falls in the first cycle after reset.
module pcg_symbol_timer #(
    parameter int SYM_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic boundary
);
    localparam int CNT_W = $clog2(SYM_LEN);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(SYM_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count down and reload the top value after the terminal state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= TOP;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign boundary = (cnt_q == '0);

endmodule

// File: rtl/pcg_phase_map.sv
// Module: combinational map from (mode, symbol) to a starting table index.
// Assumes every phase used is a multiple of STEP_DEG. Undefined codes, the
// ternary off code and reserved modes give start_on = 0.
module pcg_phase_map
    import pcg_pkg::*;
#(
    parameter int STEP_DEG = 3,
    parameter int IDX_W    = 7
) (
    input  logic [2:0]       mode,
    input  logic [2:0]       sym,
    output logic             start_on,
    output logic [IDX_W-1:0] start_idx
);
    logic [8:0] deg;

    // Decode the symbol of the selected family to a phase in degrees.
    always_comb begin
        start_on = 1'b1;
        deg      = 9'd0;
        case (pcg_mode_e'(mode))
            MODE_BIN:  deg = sym[0] ? 9'd180 : 9'd0;
            MODE_TER: begin
                case (sym[1:0])
                    2'b01:   deg = 9'd0;
                    2'b11:   deg = 9'd180;
                    default: start_on = 1'b0;
                endcase
            end
            MODE_QUAD: deg = 9'd90 * {7'd0, sym[1:0]};
            MODE_PENTA: begin
                case (sym)
                    3'b001:  deg = 9'd0;
                    3'b101:  deg = 9'd72;
                    3'b011:  deg = 9'd144;
                    3'b111:  deg = 9'd216;
                    3'b000:  deg = 9'd288;
                    default: start_on = 1'b0;
                endcase
            end
            MODE_HEXA: begin
                if (sym < 3'd6)
                    deg = 9'd60 * {6'd0, sym};
                else
                    start_on = 1'b0;
            end
            default:   start_on = 1'b0;
        endcase
    end

    // Convert degrees to a table index.
    always_comb begin
        start_idx = IDX_W'(int'(deg) / STEP_DEG);
    end

endmodule

// File: rtl/pcg_phase_walk.sv
// Module: loadable phase counter that wraps modulo TABLE_LEN.
// Assumes the load carries priority over the increment and wrap.
module pcg_phase_walk #(
    parameter int TABLE_LEN = 120,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_on,
    input  logic [IDX_W-1:0] load_idx,
    output logic             walk_on,
    output logic [IDX_W-1:0] walk_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TABLE_LEN - 1);

    // Load the start index at a boundary, otherwise step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_idx <= '0;
            walk_on  <= 1'b0;
        end else if (load) begin
            walk_idx <= load_idx;
            walk_on  <= load_on;
        end else if (walk_idx == LAST) begin
            walk_idx <= '0;
        end else begin
            walk_idx <= walk_idx + 1'b1;
        end
    end

endmodule

// File: rtl/pcg_sine_rom.sv
// Module: one-period sine table with a registered, offset-binary output.
// The table is computed at elaboration from an integer sine approximation,
// so no contents are written out. Assumes STEP_DEG divides 360.
module pcg_sine_rom
    import pcg_pkg::*;
#(
    parameter int STEP_DEG = 3,
    parameter int SAMPLE_W = 8,
    parameter int IDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_on,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld
);
    localparam int TABLE_LEN = FULL_TURN_DEG / STEP_DEG;
    localparam int MID       = 2 ** (SAMPLE_W - 1);
    localparam int AMP       = MID - 1;

    typedef logic [TABLE_LEN*SAMPLE_W-1:0] table_t;

    // Build the table with a rational sine approximation over each half turn.
    function automatic table_t build_table();
        table_t t;
        t = '0;
        for (int i = 0; i < TABLE_LEN; i++) begin
            int a, h, p, mag, v;
            a   = i * STEP_DEG;
            h   = a % HALF_TURN_DEG;
            p   = h * (HALF_TURN_DEG - h);
            mag = (AMP * 4 * p) / (40500 - p);
            v   = (a < HALF_TURN_DEG) ? (MID + mag) : (MID - mag);
            t[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(v);
        end
        return t;
    endfunction

    localparam table_t SINE_TAB = build_table();

    logic [SAMPLE_W-1:0] rd_word;

    // Select the addressed entry.
    always_comb begin
        rd_word = SINE_TAB[int'(rd_idx)*SAMPLE_W +: SAMPLE_W];
    end

    // Register the sample; a silenced window gives mid-scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample     <= SAMPLE_W'(MID);
            sample_vld <= 1'b0;
        end else begin
            sample     <= rd_on ? rd_word : SAMPLE_W'(MID);
            sample_vld <= rd_on;
        end
    end

endmodule

// File: rtl/pcg_sine_gen.sv
// Module: top of the phase-coded sine generator. The symbol timer marks
// windows, the phase map picks the start index, the phase walk steps through
// the table, and the sine table drives the DAC code.
// Assumes upstream presents mode and symbol while sym_req is high.
module pcg_sine_gen #(
    parameter int SYM_LEN  = 64,
    parameter int STEP_DEG = 3,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode,
    input  logic [2:0]          sym,
    output logic                sym_req,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld
);
    localparam int TABLE_LEN = 360 / STEP_DEG;
    localparam int IDX_W     = $clog2(TABLE_LEN);

    logic             start_on;
    logic [IDX_W-1:0] start_idx;
    logic             walk_on;
    logic [IDX_W-1:0] walk_idx;

    pcg_symbol_timer #(.SYM_LEN(SYM_LEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (sym_req)
    );

    pcg_phase_map #(.STEP_DEG(STEP_DEG), .IDX_W(IDX_W)) u_map (
        .mode      (mode),
        .sym       (sym),
        .start_on  (start_on),
        .start_idx (start_idx)
    );

    pcg_phase_walk #(.TABLE_LEN(TABLE_LEN), .IDX_W(IDX_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sym_req),
        .load_on  (start_on),
        .load_idx (start_idx),
        .walk_on  (walk_on),
        .walk_idx (walk_idx)
    );

    pcg_sine_rom #(.STEP_DEG(STEP_DEG), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_on      (walk_on),
        .rd_idx     (walk_idx),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

endmodule

// File: rtl/pcg_sine_gen_checker.sv
// Module: property checker bound to the top; observes ports only.
// Assumes the clear is synchronous and active low.
module pcg_sine_gen_checker #(
    parameter int SYM_LEN  = 64,
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          mode,
    input logic [2:0]          sym,
    input logic                sym_req,
    input logic [SAMPLE_W-1:0] sample,
    input logic                sample_vld
);
    int   gap_q;
    logic armed_q;

    // Count cycles since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= 0;
            armed_q <= 1'b0;
        end else if (sym_req) begin
            gap_q   <= 0;
            armed_q <= 1'b1;
        end else begin
            gap_q   <= gap_q + 1;
        end
    end

    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req && armed_q) |-> (gap_q == SYM_LEN - 1));

    assert_vld_only_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sym_req, 2) |-> $stable(sample_vld));

    assert_ternary_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req && mode == 3'd1 && sym[1:0] == 2'b00) |=> ##1 !sample_vld);

    assert_reserved_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req && mode > 3'd4) |=> ##1 !sample_vld);

    assert_silent_midscale_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> (sample == SAMPLE_W'(2 ** (SAMPLE_W - 1))));

endmodule

bind pcg_sine_gen pcg_sine_gen_checker #(.SYM_LEN(SYM_LEN), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .sym        (sym),
    .sym_req    (sym_req),
    .sample     (sample),
    .sample_vld (sample_vld)
);

// File: tb/pcg_sine_gen_bench.sv
// Bench: scoreboard. The driver task pushes 64 predicted samples per symbol;
// the monitor pops and compares them in the cycle each one is due.
module pcg_sine_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [2:0] sym = 3'd0;
    logic       sym_req;
    logic [7:0] sample;
    logic       sample_vld;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_req = -1;

    typedef struct {
        int    due;
        bit    vld;
        int    val;
        string tag;
    } item_t;

    item_t q[$];

    pcg_sine_gen u_pcg_sine_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sym        (sym),
        .sym_req    (sym_req),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Table entry per R4.
    function automatic int tab(input int i);
        int a, h, p, mag;
        a   = 3 * i;
        h   = a % 180;
        p   = h * (180 - h);
        mag = (508 * p) / (40500 - p);
        return (a < 180) ? 128 + mag : 128 - mag;
    endfunction

    // Phase in degrees per R5 to R10; -1 means silenced.
    function automatic int phase_of(input int m, input int s);
        case (m)
            0: return (s & 1) ? 180 : 0;
            1: case (s & 3)
                   1: return 0;
                   3: return 180;
                   default: return -1;
               endcase
            2: return 90 * (s & 3);
            3: case (s)
                   1: return 0;
                   5: return 72;
                   3: return 144;
                   7: return 216;
                   0: return 288;
                   default: return -1;
               endcase
            4: return (s < 6) ? 60 * s : -1;
            default: return -1;
        endcase
    endfunction

    // Drive one symbol at the strobe and predict its window.
    task automatic send(input int m, input int s, input string tag);
        int ph;
        do @(negedge clk); while (!sym_req);
        mode = 3'(m);
        sym  = 3'(s);
        ph   = phase_of(m, s);
        for (int k = 0; k < 64; k++) begin
            item_t it;
            it.due = cyc + 2 + k;
            it.vld = (ph >= 0);
            it.val = (ph >= 0) ? tab((ph / 3 + k) % 120) : 8'h80;
            it.tag = tag;
            q.push_back(it);
        end
        @(negedge clk);
        // R3: scramble the inputs inside the window.
        mode = ~3'(m);
        sym  = ~3'(s);
    endtask

    // Monitor: compare the due item and the strobe spacing.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n) begin
                last_req = -1;
            end else if (sym_req) begin
                if (last_req >= 0)
                    check(cyc - last_req == 64, "R2 strobe period", cyc - last_req, 64);
                last_req = cyc;
            end
            if (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                check(sample_vld == it.vld, {it.tag, " vld"}, int'(sample_vld), int'(it.vld));
                check(int'(sample) == it.val, {it.tag, " sample"}, int'(sample), it.val);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sample == 8'h80, "R1 reset sample", int'(sample), 8'h80);
        check(sample_vld == 1'b0, "R1 reset vld", int'(sample_vld), 0);
        rst_n = 1'b1;
        #1;
        check(sym_req == 1'b1, "R1 strobe after reset", int'(sym_req), 1);
        // Binary, including ignored upper bits (R5), with R3 scrambling.
        send(0, 0, "R5 bin 0");
        send(0, 1, "R5 bin 1");
        send(0, 6, "R5 bin 110");
        send(0, 7, "R5 bin 111 R3");
        // Ternary (R6, R11).
        send(1, 1, "R6 ter 01");
        send(1, 3, "R6 ter 11");
        send(1, 0, "R6 R11 ter off");
        send(1, 2, "R6 ter 10");
        // Quaternary (R7), wrap inside the window from 270 degrees (R4).
        for (int s = 0; s < 4; s++) send(2, s, "R7 R4 quad");
        // Five-phase (R8), all codes.
        for (int s = 0; s < 8; s++) send(3, s, "R8 penta");
        // Six-phase (R9), all codes.
        for (int s = 0; s < 8; s++) send(4, s, "R9 hexa");
        // Reserved modes (R10).
        for (int m = 5; m < 8; m++) send(m, 1, "R10 reserved");
        send(0, 1, "R5 bin after reserved");
        while (q.size() > 0) @(negedge clk);
        // R1: clear in the middle of a window.
        rst_n = 1'b0;
        @(negedge clk);
        check(sample == 8'h80, "R1 clear sample", int'(sample), 8'h80);
        check(sample_vld == 1'b0, "R1 clear vld", int'(sample_vld), 0);
        rst_n = 1'b1;
        #1;
        check(sym_req == 1'b1, "R1 strobe after clear", int'(sym_req), 1);
        send(2, 1, "R7 after clear");
        while (q.size() > 0) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule